// File: doc/BRIEF.md
# Buffered SPI Master with Chip-Select Hold

This block is a memory-mapped SPI master that moves a block of bytes through a single on-chip buffer. The host writes up to 1024 bytes into the buffer. It then writes one control word that carries the byte count and a start flag. The engine sends the bytes in slot order. Each byte it receives is written back into the slot it just sent from, so when the burst ends the buffer holds the read data. A completion flag is set at the end of every burst, and an interrupt is raised when the enable bit is set.

Chip select is kept asserted between bursts unless a burst carries the "final" flag. A long transaction can therefore be cut into buffer-sized pieces without a chip-select gap. A separate control write without the start flag releases chip select before a new transaction. The serial clock idles low and the far end is sampled on its rising edge. The half period is set by a programmable divider.

Top module: `spi_burst_master`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, irq is 0, the control word reads 0x0000 and the divider register reads 2.
- R2: Bus byte addresses 0x000–0x3FF select buffer slots (the slot takes bus_wdata[7:0] and reads back zero-extended). 0x400 is the control word and 0x402 the divider. Read data appears on bus_rdata after the first rising clock edge following a read strobe.
- R3: Writing the control word with bit 15 set while idle starts a burst of bits [9:0] bytes, where 0 means 1024. Slots 0..n-1 are sent in increasing order, most significant bit first.
- R4: sclk is low whenever no burst is running and whenever cs_n is high. mosi changes only while sclk is low, and miso is captured as sclk rises.
- R5: Every high phase of sclk lasts exactly divider+1 system clocks.
- R6: The byte received during slot k's transfer replaces the content of slot k.
- R7: Control bit 15 reads 1 from the cycle after a start write until the burst has ended.
- R8: While a burst runs, writes to the buffer and to the length field (bits [9:0]) are ignored.
- R9: Control bit 12 is set when a burst ends and is cleared by writing 1 to it. irq is high exactly when bit 12 and the enable bit 13 are both 1.
- R10: cs_n goes low when a burst starts. It stays low after a burst whose bit 14 was 0, and goes high after a burst whose bit 14 was 1.
- R11: While idle, a control write with bit 14 set and bit 15 clear drives cs_n high at once. A control write of zero leaves cs_n unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register/buffer write strobe |
| bus_rd | input | 1 | Register/buffer read strobe |
| bus_addr | input | 11 | Byte address within the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after the strobe |
| irq | output | 1 | Completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
A behavioural SPI slave answers with a running byte sequence and records what it shifts in. This tests transmit order and in-place write-back together on short bursts, on a full 1024-byte burst selected by a zero length, and at divider settings of 0, 2 and 5. A chain of bursts without the final flag, followed by release writes, separates a held chip select from a released one. Writes made in the middle of a slow burst, and interrupts taken with the enable both on and off, separate the ignore rules and the pending/enable split from ordinary register behaviour.

// File: rtl/spi_bm_pkg.sv
// Shared types and control-word bit positions for the burst SPI master.
package spi_bm_pkg;
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_LOAD,
        ENG_SHIFT,
        ENG_STORE
    } eng_state_t;

    localparam int CTL_GO_BIT   = 15;
    localparam int CTL_FIN_BIT  = 14;
    localparam int CTL_IEN_BIT  = 13;
    localparam int CTL_PEND_BIT = 12;
endpackage

// File: rtl/spi_buf_ram.sv
// Single-port byte buffer with synchronous read.
// Assumes one owner per cycle; the caller muxes address and write enable.
module spi_buf_ram #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [7:0]    wd,
    output logic [7:0]    q
);
    logic [7:0] mem [DEPTH];

    // Write on enable, registered read of the addressed slot.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wd;
        q <= mem[addr];
    end
endmodule

// File: rtl/spi_clk_div.sv
// Half-period tick generator: while en is high it pulses tick once every
// div+1 clocks. Assumes div is held constant while en is high.
module spi_clk_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    // Count up while enabled, restart on each tick or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= div));
endmodule

// File: rtl/spi_shift_engine.sv
// Byte engine: for each slot it reads the buffer, shifts the byte out
// in mode 0 (MSB first), captures the reply on rising sclk, and writes it back
// into the same slot. Assumes nbytes is in 1..DEPTH and that div stays
// constant while busy.
module spi_shift_engine
    import spi_bm_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DIV_W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW:0]      nbytes,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    input  logic [7:0]       ram_q,
    output logic [AW-1:0]    ram_addr,
    output logic             ram_we,
    output logic [7:0]       ram_wd,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             mosi
);
    eng_state_t  state;
    logic [AW-1:0] idx;
    logic [AW:0]   last_idx;
    logic [2:0]    bitn;
    logic [7:0]    txsh;
    logic [7:0]    rxsh;
    logic          sclk_q;
    logic          done_q;
    logic          tick;
    logic          at_last;

    spi_clk_div #(.DIV_W(DIV_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ENG_SHIFT),
        .div   (div),
        .tick  (tick)
    );

    assign at_last  = ({1'b0, idx} == last_idx);
    assign busy     = (state != ENG_IDLE);
    assign done     = done_q;
    assign sclk     = sclk_q;
    assign mosi     = txsh[7];
    assign ram_addr = idx;
    assign ram_we   = (state == ENG_STORE);
    assign ram_wd   = rxsh;

    // Sequence fetch, load, shift and store for every slot of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            idx      <= '0;
            last_idx <= '0;
            bitn     <= '0;
            txsh     <= '0;
            rxsh     <= '0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ENG_IDLE: if (start) begin
                    idx      <= '0;
                    last_idx <= nbytes - 1'b1;
                    state    <= ENG_FETCH;
                end
                ENG_FETCH: state <= ENG_LOAD;
                ENG_LOAD: begin
                    txsh  <= ram_q;
                    bitn  <= '0;
                    state <= ENG_SHIFT;
                end
                ENG_SHIFT: if (tick) begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rxsh   <= {rxsh[6:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bitn == 3'd7) begin
                            state <= ENG_STORE;
                        end else begin
                            bitn <= bitn + 1'b1;
                            txsh <= {txsh[6:0], 1'b0};
                        end
                    end
                end
                ENG_STORE: begin
                    if (at_last) begin
                        state  <= ENG_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ENG_FETCH;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));
    a_r5_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> $past(tick));
endmodule

// File: rtl/spi_burst_master.sv
// Top level: register window (buffer, control word, divider), chip-select
// hold logic and completion interrupt around the byte engine.
// Assumes one bus access per cycle and a buffer depth of at most 4096 bytes.
module spi_burst_master
    import spi_bm_pkg::*;
#(
    parameter int BUF_DEPTH = 1024,
    parameter int DIV_W     = 16,
    parameter int DIV_RST   = 2,
    localparam int AW     = $clog2(BUF_DEPTH),
    localparam int BUS_AW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam logic [BUS_AW-1:0] CTL_ADDR = BUS_AW'(BUF_DEPTH);
    localparam logic [BUS_AW-1:0] DIV_ADDR = BUS_AW'(BUF_DEPTH + 2);

    logic [AW-1:0]    len_q;
    logic             ien_q, pend_q, fin_q, cs_q;
    logic [DIV_W-1:0] div_q;
    logic [15:0]      rd_reg_q;
    logic             rd_ram_q;
    logic             eng_busy, eng_done, eng_we;
    logic [AW-1:0]    eng_addr;
    logic [7:0]       eng_wd, ram_q;
    logic             in_buf, wr_ctl, wr_div, wr_buf, go;
    logic [AW:0]      go_len;
    logic [15:0]      ctl_word;
    logic             unused_wbits;

    assign in_buf = (bus_addr < CTL_ADDR);
    assign wr_ctl = bus_wr && (bus_addr == CTL_ADDR);
    assign wr_div = bus_wr && (bus_addr == DIV_ADDR) && !eng_busy;
    assign wr_buf = bus_wr && in_buf && !eng_busy;
    assign go     = wr_ctl && bus_wdata[CTL_GO_BIT] && !eng_busy;
    assign go_len = (bus_wdata[AW-1:0] == '0) ? (AW+1)'(BUF_DEPTH)
                                              : {1'b0, bus_wdata[AW-1:0]};
    assign unused_wbits = ^bus_wdata[CTL_PEND_BIT-1:AW];

    // Assemble the control word seen by a read.
    always_comb begin
        ctl_word               = '0;
        ctl_word[AW-1:0]       = len_q;
        ctl_word[CTL_PEND_BIT] = pend_q;
        ctl_word[CTL_IEN_BIT]  = ien_q;
        ctl_word[CTL_FIN_BIT]  = fin_q;
        ctl_word[CTL_GO_BIT]   = eng_busy;
    end

    spi_buf_ram #(.DEPTH(BUF_DEPTH)) i_ram (
        .clk  (clk),
        .addr (eng_busy ? eng_addr : bus_addr[AW-1:0]),
        .we   (eng_busy ? eng_we : wr_buf),
        .wd   (eng_busy ? eng_wd : bus_wdata[7:0]),
        .q    (ram_q)
    );

    spi_shift_engine #(.DEPTH(BUF_DEPTH), .DIV_W(DIV_W)) i_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (go),
        .nbytes   (go_len),
        .div      (div_q),
        .miso     (miso),
        .ram_q    (ram_q),
        .ram_addr (eng_addr),
        .ram_we   (eng_we),
        .ram_wd   (eng_wd),
        .busy     (eng_busy),
        .done     (eng_done),
        .sclk     (sclk),
        .mosi     (mosi)
    );

    // Control fields, pending flag and chip-select hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            ien_q  <= 1'b0;
            pend_q <= 1'b0;
            fin_q  <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            if (eng_done)                            pend_q <= 1'b1;
            else if (wr_ctl && bus_wdata[CTL_PEND_BIT]) pend_q <= 1'b0;
            if (wr_ctl) begin
                ien_q <= bus_wdata[CTL_IEN_BIT];
                if (!eng_busy) begin
                    len_q <= bus_wdata[AW-1:0];
                    fin_q <= bus_wdata[CTL_FIN_BIT];
                end
            end
            if (eng_done && fin_q) cs_q <= 1'b0;
            if (wr_ctl && !eng_busy && bus_wdata[CTL_FIN_BIT] && !bus_wdata[CTL_GO_BIT])
                cs_q <= 1'b0;
            if (go) cs_q <= 1'b1;
        end
    end

    // Clock divider register, frozen while a burst runs.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= DIV_W'(DIV_RST);
        else if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
    end

    // Register the read path: register words directly, buffer via RAM output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_reg_q <= '0;
            rd_ram_q <= 1'b0;
        end else if (bus_rd) begin
            rd_ram_q <= in_buf;
            rd_reg_q <= (bus_addr == CTL_ADDR) ? ctl_word :
                        (bus_addr == DIV_ADDR) ? 16'(div_q) : 16'h0000;
        end
    end

    assign bus_rdata = rd_ram_q ? {8'h00, ram_q} : rd_reg_q;
    assign irq       = pend_q && ien_q;
    assign cs_n      = !cs_q;

    a_r9_pend_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> pend_q);
    a_r10_cs_during_burst: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !cs_n);
    a_r8_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> $stable(len_q));
    a_r4_sclk_cs: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
endmodule

// File: tb/test_spi_burst_master.sv
module test_spi_burst_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, sclk, mosi, cs_n;
    logic        miso = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    logic [7:0] ref_buf [1024];
    int         div_model = 2;

    // behavioural SPI slave
    logic [7:0] s_tx = '0, s_rx = '0;
    int         s_bit = 0, s_seq = 0;
    logic [7:0] sent_q[$];
    logic [7:0] got_q[$];

    always #2 clk = ~clk;

    spi_burst_master i_spi_burst_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    function automatic logic [7:0] next_byte();
        s_seq++;
        return 8'(s_seq * 29) ^ 8'h3C;
    endfunction

    always @(negedge cs_n) begin
        s_tx = next_byte();
        s_bit = 0;
        miso = s_tx[7];
    end
    always @(posedge sclk) if (!cs_n) s_rx = {s_rx[6:0], mosi};
    always @(negedge sclk) if (!cs_n) begin
        s_bit++;
        if (s_bit == 8) begin
            got_q.push_back(s_rx);
            sent_q.push_back(s_tx);
            s_bit = 0;
            s_tx = next_byte();
        end
        miso = s_tx[7 - s_bit];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // per-clock reference: high-phase length (R5) and idle clock with cs high (R4)
    int hi_cnt = 0;
    always @(negedge clk) if (rst_n) begin
        if (cs_n) chk(!sclk, "R4 sclk low while cs_n high", sclk, 0);
        if (sclk) hi_cnt++;
        else if (hi_cnt != 0) begin
            chk(hi_cnt == div_model + 1, "R5 sclk high phase", hi_cnt, div_model + 1);
            hi_cnt = 0;
        end
    end

    task automatic bus_write(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic buf_fill(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            ref_buf[i] = 8'(i) ^ seed;
            bus_write(11'(i), {8'h00, ref_buf[i]});
        end
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int k = 0; k < 20000; k++) begin
            bus_read(11'h400, v);
            if (!v[15]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_burst(input int n, input bit fin, input bit ien, input bit poke);
        logic [15:0] v;
        int base, bad;
        base = got_q.size();
        bus_write(11'h400, 16'h8000 | (16'(fin) << 14) | (16'(ien) << 13) | 16'(n % 1024));
        bus_read(11'h400, v);
        chk(v[15], "R7 busy after start", v[15], 1);
        if (poke) begin
            bus_write(11'd100, 16'h00EE);
            bus_write(11'h400, 16'h0005);
        end
        wait_idle();
        chk(got_q.size() == base + n, "R3 byte count", got_q.size() - base, n);
        bad = 0;
        for (int i = 0; i < n && base + i < got_q.size(); i++)
            if (got_q[base + i] != ref_buf[i]) bad++;
        chk(bad == 0, "R3 transmit order MSB first", bad, 0);
        bad = 0;
        for (int i = 0; i < n && base + i < sent_q.size(); i++) begin
            bus_read(11'(i), v);
            if (v != {8'h00, sent_q[base + i]}) bad++;
            ref_buf[i] = sent_q[base + i];
        end
        chk(bad == 0, "R6 in-place receive", bad, 0);
        bus_read(11'h400, v);
        chk(v[12], "R9 pending set at end", v[12], 1);
        chk(v[9:0] == 10'(n % 1024), "R8 length field kept", v[9:0], n % 1024);
        chk(cs_n == fin, "R10 cs after burst", cs_n, fin);
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_sim();
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk reset", sclk, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        bus_read(11'h400, v);
        chk(v == 16'h0000, "R1 control reset", v, 0);
        bus_read(11'h402, v);
        chk(v == 16'd2, "R1 divider reset", v, 2);

        // R2 buffer write/readback
        buf_fill(128, 8'hC3);
        bus_read(11'd77, v);
        chk(v == {8'h00, ref_buf[77]}, "R2 buffer readback", v, ref_buf[77]);

        // final burst with interrupt enabled
        run_burst(4, 1'b1, 1'b1, 1'b0);
        chk(irq == 1'b1, "R9 irq with enable", irq, 1);
        bus_write(11'h400, 16'h3000);
        bus_read(11'h400, v);
        chk(v[12] == 1'b0, "R9 pending write-one clear", v[12], 0);
        chk(irq == 1'b0, "R9 irq after clear", irq, 0);

        // held chip select across bursts, divider 0 then 5
        bus_write(11'h402, 16'd0);
        div_model = 0;
        bus_read(11'h402, v);
        chk(v == 16'd0, "R2 divider readback", v, 0);
        run_burst(3, 1'b0, 1'b0, 1'b0);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        bus_write(11'h402, 16'd5);
        div_model = 5;
        run_burst(2, 1'b1, 1'b0, 1'b1);
        bus_read(11'd100, v);
        chk(v == {8'h00, ref_buf[100]}, "R8 buffer write ignored while busy", v, ref_buf[100]);

        // forced release
        bus_write(11'h402, 16'd2);
        div_model = 2;
        run_burst(2, 1'b0, 1'b0, 1'b0);
        bus_write(11'h400, 16'h0000);
        chk(cs_n == 1'b0, "R11 zero write keeps cs", cs_n, 0);
        bus_write(11'h400, 16'h4000);
        chk(cs_n == 1'b1, "R11 release write", cs_n, 1);
        bus_write(11'h400, 16'h0000);
        chk(cs_n == 1'b1, "R11 stays released", cs_n, 1);

        // full-buffer burst selected by zero length
        bus_write(11'h402, 16'd0);
        div_model = 0;
        buf_fill(1024, 8'h5A);
        run_burst(1024, 1'b1, 1'b0, 1'b0);

        finish_sim();
    end
endmodule